// File: doc/BRIEF.md
# Nine-bit stack pointer unit

This unit owns the processor's stack pointer, a register one bit wider than a data byte, and performs every operation that moves or exposes it. A frame can be opened or closed in one step by adding a signed byte to the pointer. Single bytes are pushed and pulled through a memory address and strobes that the unit drives. The pointer can be loaded from the accumulator and index pair. Its value can be read back either as a low byte alone or as a high:low pair in the index and accumulator positions.

Each cycle the surrounding decoder presents one operation code with the accumulator, index, immediate and data byte values. Address, strobes and read-back results are combinational in that cycle. The pointer changes at the following rising clock edge. The stack occupies a window of memory whose base is a parameter, and the pointer gives the offset inside that window.

Top module: `sp_unit`

## Requirements
- R1: A synchronous active-high reset sets the pointer to 0x1FF (all ones), and this value is visible on `sp` in the cycle after reset is released.
- R2: Operation code 1 (adjust) adds the 8-bit two's-complement `imm` to the pointer at the clock edge, modulo 512. A negative value opens frame space and a positive value releases it.
- R3: Operation code 2 (push) raises `mem_wr` in the same cycle, with `mem_addr` = base + S and `mem_wdata` equal to `wr_data`. At the clock edge the pointer then decrements by one, modulo 512.
- R4: Operation code 3 (pull) raises `mem_rd` in the same cycle, with `mem_addr` = base + ((S + 1) mod 512). At the clock edge the pointer increments by one, modulo 512.
- R5: Operation code 4 (load) sets the pointer to {`x_in` bit 0, `a_in`} at the clock edge. Bits 7..1 of `x_in` have no effect.
- R6: Operation code 5 (to-A) drives `res_a` with pointer bits 7..0 and passes `x_in` to `res_x` unchanged. The pointer's top bit is dropped.
- R7: Operation code 6 (to-XA) drives `res_a` with pointer bits 7..0 and `res_x` with the pointer's top bit in bit 0, with zeros above it.
- R8: Operation codes 0 and 7 leave the pointer unchanged and raise no strobe. For every code other than 5 and 6, `res_a` and `res_x` pass `a_in` and `x_in` through. `mem_wr` and `mem_rd` are never high together.
- R9: Wrap-around: a push at S = 0 leaves S = 0x1FF, and a pull at S = 0x1FF addresses base + 0 and leaves S = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Operation code (encodings in R2 to R8) |
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | Index value; bit 0 supplies the pointer's top bit on load |
| imm | input | 8 | Signed adjustment for operation code 1 |
| wr_data | input | 8 | Byte to be pushed |
| sp | output | 9 | Current stack pointer |
| mem_addr | output | 16 | Stack memory address for push and pull |
| mem_wr | output | 1 | Write strobe, high during a push |
| mem_rd | output | 1 | Read strobe, high during a pull |
| mem_wdata | output | 8 | Byte written during a push |
| res_a | output | 8 | Accumulator result |
| res_x | output | 8 | Index result |

## Verification
The bench builds the unit with the default 9-bit pointer and 8-bit data, but moves the stack base to 0x4000. A design that ignored the base, or merged it wrongly with the pointer, would then put out a visibly wrong address. With a 9-bit pointer the wrap points at 0 and 0x1FF can be reached in a few directed steps, and the largest positive and negative adjustments (+127, -128) are applied directly. A long run of random operations then checks every mixing of codes against the reference model.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [2:0] {
      SP_OP_IDLE = 3'd0,
      SP_OP_ADJ  = 3'd1,
      SP_OP_PUSH = 3'd2,
      SP_OP_PULL = 3'd3,
      SP_OP_LOAD = 3'd4,
      SP_OP_TOA  = 3'd5,
      SP_OP_TOXA = 3'd6,
      SP_OP_RSVD = 3'd7
   } sp_op_e;

endpackage

// File: rtl/sp_next.sv
module sp_next
   import sp_pkg::*;
#(
   parameter int SP_W   = 9,
   parameter int DATA_W = 8,
   localparam int HI_W  = SP_W - DATA_W
) (
   input  sp_op_e            op,
   input  logic [SP_W-1:0]   sp_q,
   input  logic [DATA_W-1:0] a,
   input  logic [HI_W-1:0]   x_lo,
   input  logic [DATA_W-1:0] imm,
   output logic [SP_W-1:0]   sp_d
);

   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   logic [SP_W-1:0] imm_sx;
   assign imm_sx = {{HI_W{imm[DATA_W-1]}}, imm};

   always_comb begin
      unique case (op)
         SP_OP_ADJ:  sp_d = sp_q + imm_sx;
         SP_OP_PUSH: sp_d = sp_q - ONE;
         SP_OP_PULL: sp_d = sp_q + ONE;
         SP_OP_LOAD: sp_d = {x_lo, a};
         default:    sp_d = sp_q;
      endcase
   end

endmodule

// File: rtl/sp_addr.sv
module sp_addr
   import sp_pkg::*;
#(
   parameter int                SP_W       = 9,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] STACK_BASE = '0
) (
   input  sp_op_e            op,
   input  logic [SP_W-1:0]   sp_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr,
   output logic              mem_rd
);

   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   logic [SP_W-1:0] offset;

   always_comb begin
      mem_wr = (op == SP_OP_PUSH);
      mem_rd = (op == SP_OP_PULL);
      offset = mem_rd ? (sp_q + ONE) : sp_q;
   end

   generate
      if (ADDR_W == SP_W) begin : g_flat
         assign mem_addr = offset;
      end else begin : g_windowed
         assign mem_addr = {STACK_BASE[ADDR_W-1:SP_W], offset};
      end
   endgenerate

endmodule

// File: rtl/sp_result.sv
module sp_result
   import sp_pkg::*;
#(
   parameter int SP_W   = 9,
   parameter int DATA_W = 8,
   localparam int HI_W  = SP_W - DATA_W
) (
   input  sp_op_e            op,
   input  logic [SP_W-1:0]   sp_q,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] x,
   output logic [DATA_W-1:0] res_a,
   output logic [DATA_W-1:0] res_x
);

   logic [DATA_W-1:0] hi_byte;

   generate
      if (HI_W == DATA_W) begin : g_full_hi
         assign hi_byte = sp_q[SP_W-1:DATA_W];
      end else begin : g_part_hi
         assign hi_byte = {{(DATA_W-HI_W){1'b0}}, sp_q[SP_W-1:DATA_W]};
      end
   endgenerate

   always_comb begin
      res_a = a;
      res_x = x;
      if (op == SP_OP_TOA || op == SP_OP_TOXA) res_a = sp_q[DATA_W-1:0];
      if (op == SP_OP_TOXA)                    res_x = hi_byte;
   end

endmodule

// File: rtl/sp_unit.sv
module sp_unit
   import sp_pkg::*;
#(
   parameter int                SP_W       = 9,
   parameter int                DATA_W     = 8,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] STACK_BASE = '0,
   parameter logic [SP_W-1:0]   RESET_SP   = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SP_W-1:0]   sp,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr,
   output logic              mem_rd,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] res_a,
   output logic [DATA_W-1:0] res_x
);

   localparam int HI_W = SP_W - DATA_W;

   generate
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
         $error("sp_unit: pointer must be wider than one data byte and at most two");
      end
      if (ADDR_W < SP_W) begin : g_bad_addr
         $error("sp_unit: address narrower than pointer");
      end
      if (STACK_BASE[SP_W-1:0] != '0) begin : g_bad_base
         $error("sp_unit: stack base must be aligned to the pointer range");
      end
   endgenerate

   sp_op_e          op_e;
   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_d;

   assign op_e = sp_op_e'(op);

   sp_next #(.SP_W(SP_W), .DATA_W(DATA_W)) u_next (
      .op   (op_e),
      .sp_q (sp_q),
      .a    (a_in),
      .x_lo (x_in[HI_W-1:0]),
      .imm  (imm),
      .sp_d (sp_d)
   );

   sp_addr #(.SP_W(SP_W), .ADDR_W(ADDR_W), .STACK_BASE(STACK_BASE)) u_addr (
      .op       (op_e),
      .sp_q     (sp_q),
      .mem_addr (mem_addr),
      .mem_wr   (mem_wr),
      .mem_rd   (mem_rd)
   );

   sp_result #(.SP_W(SP_W), .DATA_W(DATA_W)) u_result (
      .op    (op_e),
      .sp_q  (sp_q),
      .a     (a_in),
      .x     (x_in),
      .res_a (res_a),
      .res_x (res_x)
   );

   always_ff @(posedge clk) begin
      if (rst) sp_q <= RESET_SP;
      else     sp_q <= sp_d;
   end

   assign sp        = sp_q;
   assign mem_wdata = wr_data;

endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk
   import sp_pkg::*;
#(
   parameter int              SP_W     = 9,
   parameter int              DATA_W   = 8,
   parameter logic [SP_W-1:0] RESET_SP = '1
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        op,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] x_in,
   input logic [DATA_W-1:0] imm,
   input logic [SP_W-1:0]   sp,
   input logic [SP_W-1:0]   addr_lo,
   input logic              mem_wr,
   input logic              mem_rd
);

   localparam int HI_W = SP_W - DATA_W;
   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   a_r1_reset_value: assert property (@(posedge clk)
      $past(rst) && !rst |-> sp == RESET_SP);

   a_r2_adjust: assert property (@(posedge clk) disable iff (rst)
      op == SP_OP_ADJ |=> sp == SP_W'($past(sp) + {{HI_W{$past(imm[DATA_W-1])}}, $past(imm)}));

   a_r3_push_dec: assert property (@(posedge clk) disable iff (rst)
      op == SP_OP_PUSH |=> sp == SP_W'($past(sp) - ONE));

   a_r3_push_addr: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> addr_lo == sp);

   a_r4_pull_inc: assert property (@(posedge clk) disable iff (rst)
      op == SP_OP_PULL |=> sp == SP_W'($past(sp) + ONE));

   a_r4_pull_addr: assert property (@(posedge clk) disable iff (rst)
      mem_rd |-> addr_lo == SP_W'(sp + ONE));

   a_r5_load: assert property (@(posedge clk) disable iff (rst)
      op == SP_OP_LOAD |=> sp == SP_W'({$past(x_in), $past(a_in)}));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (op == SP_OP_IDLE || op == SP_OP_RSVD) |=> $stable(sp));

   a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
      $countones({mem_wr, mem_rd}) <= 1);

endmodule

bind sp_unit sp_unit_chk #(.SP_W(SP_W), .DATA_W(DATA_W), .RESET_SP(RESET_SP)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .op      (op),
   .a_in    (a_in),
   .x_in    (x_in),
   .imm     (imm),
   .sp      (sp),
   .addr_lo (mem_addr[SP_W-1:0]),
   .mem_wr  (mem_wr),
   .mem_rd  (mem_rd)
);

// File: tb/sp_unit_test.sv
`timescale 1ns/1ps
module sp_unit_test;

   localparam logic [15:0] BASE = 16'h4000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] op = 3'd0;
   logic [7:0] a_in = 8'h00, x_in = 8'h00, imm = 8'h00, wr_data = 8'h00;
   logic [8:0] sp;
   logic [15:0] mem_addr;
   logic       mem_wr, mem_rd;
   logic [7:0] mem_wdata, res_a, res_x;

   int nchk = 0;
   int nfail = 0;
   int m_sp = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sp_unit #(.STACK_BASE(BASE)) uut (
      .clk(clk), .rst(rst), .op(op), .a_in(a_in), .x_in(x_in), .imm(imm),
      .wr_data(wr_data), .sp(sp), .mem_addr(mem_addr), .mem_wr(mem_wr),
      .mem_rd(mem_rd), .mem_wdata(mem_wdata), .res_a(res_a), .res_x(res_x)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One operation per cycle: drive at the falling edge, check the
   // combinational outputs, then advance the model at the rising edge.
   task automatic step(input int o, input int a, input int x, input int im,
                       input int d, input string req);
      int sx;
      @(negedge clk);
      op = o[2:0]; a_in = a[7:0]; x_in = x[7:0]; imm = im[7:0]; wr_data = d[7:0];
      #1;
      chk(req, "sp", {23'd0, sp}, m_sp);
      chk(req, "mem_wr", {31'd0, mem_wr}, (o[2:0] == 3'd2) ? 1 : 0);
      chk(req, "mem_rd", {31'd0, mem_rd}, (o[2:0] == 3'd3) ? 1 : 0);
      if (o[2:0] == 3'd2) begin
         chk(req, "push addr", {16'd0, mem_addr}, BASE + m_sp);
         chk(req, "push data", {24'd0, mem_wdata}, d & 255);
      end
      if (o[2:0] == 3'd3)
         chk(req, "pull addr", {16'd0, mem_addr}, BASE + ((m_sp + 1) & 511));
      chk(req, "res_a", {24'd0, res_a},
          (o[2:0] == 3'd5 || o[2:0] == 3'd6) ? (m_sp & 255) : (a & 255));
      chk(req, "res_x", {24'd0, res_x},
          (o[2:0] == 3'd6) ? (m_sp >> 8) : (x & 255));
      case (o[2:0])
         3'd1: begin
            sx = im & 255;
            if (sx >= 128) sx -= 256;
            m_sp = (m_sp + sx + 512) & 511;
         end
         3'd2: m_sp = (m_sp + 511) & 511;
         3'd3: m_sp = (m_sp + 1) & 511;
         3'd4: m_sp = ((x & 1) << 8) | (a & 255);
         default: ;
      endcase
      @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      m_sp = 511;
      chk("R1", "sp after reset", {23'd0, sp}, 511);

      // R3 pushes from the reset value, R4 pull
      step(2, 0, 0, 0, 8'hA5, "R3");
      step(2, 0, 0, 0, 8'h5A, "R3");
      step(3, 0, 0, 0, 0, "R4");
      // R2 adjust in both directions, extremes
      step(1, 0, 0, -4, 0, "R2");
      step(1, 0, 0, 4, 0, "R2");
      step(1, 0, 0, -128, 0, "R2");
      step(1, 0, 0, 127, 0, "R2");
      // R5 load, only bit 0 of X used
      step(4, 8'h34, 8'h01, 0, 0, "R5");
      step(6, 8'h11, 8'h22, 0, 0, "R7");
      step(5, 8'h11, 8'h22, 0, 0, "R6");
      step(4, 8'h34, 8'hFE, 0, 0, "R5");
      step(6, 8'h99, 8'h77, 0, 0, "R7");
      // R8 idle and reserved codes hold S
      step(0, 8'h12, 8'h34, 8'h80, 8'hFF, "R8");
      step(7, 8'h56, 8'h78, 8'h7F, 8'hFF, "R8");
      step(0, 8'h9A, 8'hBC, 0, 0, "R8");
      // R9 wrap cases
      step(4, 0, 0, 0, 0, "R9");
      step(2, 0, 0, 0, 8'h3C, "R9");
      step(4, 8'hFF, 8'h01, 0, 0, "R9");
      step(3, 0, 0, 0, 0, "R9");
      step(4, 8'h05, 8'h00, 0, 0, "R9");
      step(1, 0, 0, -16, 0, "R9");
      step(1, 0, 0, 127, 0, "R9");
      step(0, 0, 0, 0, 0, "R9");
      // random mix over all codes
      for (int i = 0; i < 400; i++) begin
         int o;
         o = int'($urandom_range(0, 7));
         step(o, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              (o == 1) ? "R2" : (o == 2) ? "R3" : (o == 3) ? "R4" :
              (o == 4) ? "R5" : (o == 5) ? "R6" : (o == 6) ? "R7" : "R8");
      end
      step(0, 0, 0, 0, 0, "R8");
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule